// File: doc/BRIEF.md
# Dual-Mode Display Data Streamer

This block sends the contents of a small byte memory out over a one-way serial line, one bit per rising edge of an externally supplied transmit clock. After reset it stays silent, with its output released, through a fixed synchronisation window of nine transmit-clock rising edges. From the tenth edge on, it sends bytes most significant bit first, each followed by a ninth null bit. Bytes come from consecutive addresses, and the address wraps back to zero after the last location.

A second clock input belongs to a bidirectional two-wire bus. The first falling edge seen on that line locks the block into bidirectional mode. Streaming stops, the data output is released and a mode flag is raised for a separate protocol engine. Only reset brings the block back to streaming.

Both clock inputs are asynchronous to the system clock. Each is synchronised through two flops and then edge-detected. The starting address after reset is taken from an input, and the memory read port has one cycle of latency.

Top module: `disp_stream`

## Requirements
- R1: While reset is asserted, `bidir_mode` is 0, `sda_oe` is 0, `byte_done` is 0 and `mem_addr` equals `start_addr`.
- R2: During the first nine detected rising edges of `tx_clk_in` after reset, `sda_oe` stays 0.
- R3: On the tenth detected rising edge, `sda_oe` goes to 1 and `sda_out` carries bit 7 of the byte stored at `start_addr`.
- R4: Each later rising edge presents the next bit of the byte, going from bit 7 down to bit 0. The edge after bit 0 presents a null bit, driven as logic 1 with `sda_oe` at 1. The MSB of the next byte follows on the edge after that.
- R5: `mem_addr` advances by one on each null-bit edge, and steps from DEPTH-1 to 0. It changes at no other time.
- R6: `byte_done` is 1 for exactly one system cycle after each null-bit edge, and is 0 otherwise.
- R7: A falling edge on `bus_clk_in` sets `bidir_mode` to 1 and `sda_oe` to 0. The mode then stays at 1, whatever later level the bus clock takes.
- R8: In bidirectional mode, rising edges of `tx_clk_in` have no effect: `sda_oe` stays 0, `mem_addr` holds and `byte_done` stays 0. A reset returns the block to transmit-only mode.
- R9: While `bus_clk_in` is held high, the block stays in transmit-only mode for any amount of streaming.
- R10: An input level change that is first sampled at system edge n takes effect on the outputs at edge n+2. That is the third system edge counting the sampling edge, and is due to two synchroniser stages plus one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk_in | input | 1 | Asynchronous transmit clock from the display side |
| bus_clk_in | input | 1 | Asynchronous clock line of the bidirectional bus, idle high |
| start_addr | input | AW | Byte address loaded during reset |
| mem_addr | output | AW | Read address to the byte memory |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_addr` |
| sda_oe | output | 1 | Serial data output enable (0 = released) |
| sda_out | output | 1 | Serial data value when enabled |
| bidir_mode | output | 1 | 0 = transmit-only, 1 = bidirectional |
| byte_done | output | 1 | One-cycle pulse after each byte's null bit |

## Verification
The hardest state to reach is a bus-clock falling edge that arrives in the middle of a byte, after the synchronisation window has closed and the address has already wrapped. There, the address must freeze on a non-initial value and the output must release while a bit is still being driven. The stimulus first streams more than a full memory's worth of bytes from a start address near the top. It then drops the bus clock three bits into a byte, and afterwards keeps pulsing the transmit clock to show that nothing moves. A behavioural model tracks the bit position, the address and the mode from the input history, and is compared against every output on every clock.

// File: rtl/disp_stream.sv
module disp_stream #(
  parameter int DEPTH      = 256,
  parameter int DW         = 8,
  parameter int SYNC_EDGES = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = $clog2(DW + 1),
  localparam int CW = $clog2(SYNC_EDGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_clk_in,
  input  logic          bus_clk_in,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          sda_oe,
  output logic          sda_out,
  output logic          bidir_mode,
  output logic          byte_done
);

  logic [2:0]    tx_s, bus_s;
  logic          bidir_q, synced_q, oe_q, dout_q, done_q;
  logic [CW-1:0] sync_cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] shift_q;
  logic [AW-1:0] addr_q;

  wire tx_rise   = tx_s[1] & ~tx_s[2];
  wire bus_fall  = ~bus_s[1] & bus_s[2];
  wire stream_ev = tx_rise & ~bidir_q & ~bus_fall;
  wire last_sync = (sync_cnt == CW'(SYNC_EDGES));
  wire at_null   = (bit_idx == BW'(DW));
  wire load_msb  = stream_ev & (synced_q ? (bit_idx == '0) : last_sync);
  wire [AW-1:0] addr_nxt = (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;

  assign mem_addr   = addr_q;
  assign sda_oe     = oe_q;
  assign sda_out    = dout_q;
  assign bidir_mode = bidir_q;
  assign byte_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_s     <= 3'b000;
      bus_s    <= 3'b111;
      bidir_q  <= 1'b0;
      synced_q <= 1'b0;
      oe_q     <= 1'b0;
      dout_q   <= 1'b1;
      done_q   <= 1'b0;
      sync_cnt <= '0;
      bit_idx  <= '0;
      shift_q  <= '0;
      addr_q   <= start_addr;
    end else begin
      tx_s   <= {tx_s[1:0], tx_clk_in};
      bus_s  <= {bus_s[1:0], bus_clk_in};
      done_q <= 1'b0;
      if (!bidir_q && bus_fall) begin
        bidir_q <= 1'b1;
        oe_q    <= 1'b0;
        dout_q  <= 1'b1;
      end else if (load_msb) begin
        synced_q <= 1'b1;
        oe_q     <= 1'b1;
        dout_q   <= mem_rdata[DW-1];
        shift_q  <= {mem_rdata[DW-2:0], 1'b0};
        bit_idx  <= BW'(1);
      end else if (stream_ev) begin
        if (!synced_q) begin
          sync_cnt <= sync_cnt + 1'b1;
        end else if (at_null) begin
          dout_q  <= 1'b1;
          bit_idx <= '0;
          done_q  <= 1'b1;
          addr_q  <= addr_nxt;
        end else begin
          dout_q  <= shift_q[DW-1];
          shift_q <= {shift_q[DW-2:0], 1'b0};
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_q |-> !sda_oe) else $error("sync window drove line"); // R2

  AST_NULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (synced_q && bit_idx == '0 && !bidir_q) |-> (sda_oe && sda_out)) else $error("null bit low"); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |->
      (mem_addr == (($past(mem_addr) == AW'(DEPTH - 1)) ? '0 : $past(mem_addr) + 1'b1)))
    else $error("bad address step"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done) else $error("done longer than a cycle"); // R6

  AST_BIDIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> bidir_mode) else $error("left bidirectional mode"); // R7

  AST_BIDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> (!sda_oe && !byte_done)) else $error("activity in bidirectional mode"); // R8

  AST_BIDIR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bidir_mode && $past(bidir_mode)) |-> $stable(mem_addr)) else $error("address moved in bidirectional mode"); // R8

endmodule

// File: tb/sim_disp_stream.sv
module sim_disp_stream;
  localparam int DEPTH = 16;
  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b0;
  logic bus = 1'b1;
  logic [AW-1:0] start = 4'd13;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] rdata;
  logic sda_oe, sda_out, bidir_mode, byte_done;
  logic [DW-1:0] mem [DEPTH];

  int total = 0, bad = 0, cycles = 0, done_cnt = 0;

  always #2 clk = ~clk;

  disp_stream #(.DEPTH(DEPTH), .DW(DW), .SYNC_EDGES(9)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_clk_in(tx), .bus_clk_in(bus),
    .start_addr(start), .mem_addr(mem_addr), .mem_rdata(rdata),
    .sda_oe(sda_oe), .sda_out(sda_out), .bidir_mode(bidir_mode), .byte_done(byte_done));

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37 + 90) % 256);
  always @(posedge clk) rdata <= mem[mem_addr];

  // behavioural reference model
  bit th[$], bh[$];
  bit m_mode, m_oe, m_dout, m_done;
  int m_addr, m_edges, m_pos;
  logic [7:0] m_byte;
  always @(posedge clk) begin
    if (!rst_n) begin
      th = '{0, 0, 0, 0}; bh = '{1, 1, 1, 1};
      m_mode = 0; m_oe = 0; m_dout = 1; m_done = 0;
      m_addr = int'(start); m_edges = 0; m_pos = 0;
    end else begin
      bit rise, fall;
      rise = th[1] && !th[2];
      fall = !bh[1] && bh[2];
      th.push_front(tx); void'(th.pop_back());
      bh.push_front(bus); void'(bh.pop_back());
      m_done = 0;
      if (!m_mode && fall) begin
        m_mode = 1; m_oe = 0; m_dout = 1;
      end else if (!m_mode && rise) begin
        m_edges++;
        if (m_edges >= 10) begin
          if (m_pos == 0) m_byte = mem[m_addr];
          if (m_pos < 8) begin
            m_oe = 1; m_dout = m_byte[7 - m_pos]; m_pos++;
          end else begin
            m_dout = 1; m_pos = 0; m_done = 1; m_addr = (m_addr + 1) % DEPTH;
          end
        end
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (byte_done) done_cnt++;
      check(32'(sda_oe), 32'(m_oe), "R4 sda_oe vs model");
      if (m_oe) check(32'(sda_out), 32'(m_dout), "R4 sda_out vs model");
      check(32'(bidir_mode), 32'(m_mode), "R7 mode vs model");
      check(32'(byte_done), 32'(m_done), "R6 byte_done vs model");
      check(32'(mem_addr), 32'(m_addr), "R5 mem_addr vs model");
    end
  end

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_up();
  end

  task automatic pulse(input int half, input int n);
    for (int k = 0; k < n; k++) begin
      tx = 1'b1; repeat (half) @(negedge clk);
      tx = 1'b0; repeat (half) @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [AW-1:0] a);
    @(negedge clk);
    rst_n = 1'b0; start = a; tx = 1'b0; bus = 1'b1;
    repeat (3) @(negedge clk);
    check(32'(bidir_mode), 0, "R1 mode in reset");
    check(32'(sda_oe), 0, "R1 oe in reset");
    check(32'(byte_done), 0, "R1 done in reset");
    check(32'(mem_addr), 32'(a), "R1 addr in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int d0, a0;
    do_reset(4'd13);
    pulse(3, 9);
    repeat (4) @(negedge clk);
    check(32'(sda_oe), 0, "R2 oe after nine edges");
    // tenth edge with latency probe
    tx = 1'b1;
    @(negedge clk); @(negedge clk);
    check(32'(sda_oe), 0, "R10 oe before third edge");
    @(negedge clk);
    check(32'(sda_oe), 1, "R10 oe at third edge");
    check(32'(sda_out), 32'(mem[13][7]), "R3 first bit is MSB of start byte");
    repeat (2) @(negedge clk);
    tx = 1'b0; repeat (3) @(negedge clk);
    pulse(3, 8);
    repeat (4) @(negedge clk);
    check(32'(mem_addr), 14, "R5 addr after first byte");
    check(32'(done_cnt), 1, "R6 one pulse per byte");
    pulse(3, 9 * 19);
    repeat (4) @(negedge clk);
    check(32'(mem_addr), 1, "R5 addr after wrap");
    check(32'(done_cnt), 20, "R6 pulse count after wrap");
    check(32'(bidir_mode), 0, "R9 bus high keeps transmit mode");
    pulse(1, 9 * 3);
    repeat (4) @(negedge clk);
    check(32'(mem_addr), 4, "R5 addr after fast bytes");
    // mid-byte switch
    pulse(2, 3);
    a0 = int'(mem_addr); d0 = done_cnt;
    bus = 1'b0;
    @(negedge clk); @(negedge clk);
    check(32'(bidir_mode), 0, "R10 mode before third edge");
    @(negedge clk);
    check(32'(bidir_mode), 1, "R7 mode set by bus fall");
    check(32'(sda_oe), 0, "R7 line released");
    bus = 1'b1; repeat (3) @(negedge clk); bus = 1'b0; repeat (3) @(negedge clk); bus = 1'b1;
    pulse(2, 20);
    repeat (4) @(negedge clk);
    check(32'(bidir_mode), 1, "R7 mode sticky");
    check(32'(sda_oe), 0, "R8 oe stays low");
    check(32'(mem_addr), 32'(a0), "R8 addr holds");
    check(32'(done_cnt), 32'(d0), "R8 no byte pulses");
    // reset at top address
    do_reset(4'd15);
    check(32'(bidir_mode), 0, "R8 reset returns transmit mode");
    pulse(2, 9);
    tx = 1'b1; repeat (4) @(negedge clk);
    check(32'(sda_oe), 1, "R3 oe on tenth edge");
    check(32'(sda_out), 32'(mem[15][7]), "R3 MSB of top byte");
    tx = 1'b0; repeat (2) @(negedge clk);
    pulse(2, 8);
    repeat (4) @(negedge clk);
    check(32'(mem_addr), 0, "R5 wrap from top address");
    pulse(2, 9 * 2);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule